// File: doc/BRIEF.md
# Packed String Compare Engine

This block compares two 128-bit operands that each hold a short string of packed characters and returns a bit mask with one bit per character position of the second operand. Characters are either 8-bit (sixteen per operand) or 16-bit (eight per operand). Internally every character of the first operand is compared against every character of the second. The resulting grid of equal and greater-than results is then reduced in one of four ways: position-wise equality, membership in a character set, membership in a list of inclusive ranges, or the start positions of a substring.

Each operand's length is implicit: the first character whose value is zero ends it, and the comparison rules force fixed results wherever a character lies past that end. Besides the mask, the engine reports the position of the lowest set mask bit, a flag that says the second operand ended inside the block, and a flag that says the mask has at least one bit set. All outputs are registered once, so a result appears on the clock edge after its inputs are presented. A scanning loop can step through memory one 16-byte block per operation and stop on either flag.

Top module: `str_match_engine`

## Requirements
- R1: With `wide_sel`=0 the operands hold 16 byte elements, element k at bits [8k+7:8k]; with `wide_sel`=1 they hold 8 word elements, element k at bits [16k+15:16k]. In word mode `res_mask[15:8]` is always 0. Mask bit k belongs to element k of `src_b`.
- R2: An operand's valid length is the index of its first zero element, or the element count if it has none. Elements at or after that index are invalid. `flag_term` is 1 exactly when `src_b` has a zero element.
- R3: `agg_mode`=0 (position-wise): bit k is 1 when both element k's are valid and equal, or when both are invalid. It is 0 when only one of them is valid.
- R4: `agg_mode`=1 (character set): bit j is 1 when `src_b` element j is valid and equals some valid element of `src_a`.
- R5: `agg_mode`=2 (ranges): `src_a` elements 2p and 2p+1 form an inclusive unsigned lower/upper bound pair. A pair takes part only if both of its elements are valid. Bit j is 1 when `src_b` element j is valid and lies within at least one such pair.
- R6: `agg_mode`=3 (substring): bit j is 1 when, for every valid `src_a` element i, position j+i is inside the operand, `src_b` element j+i is valid, and the two are equal. An empty `src_a` therefore gives all ones.
- R7: `res_idx` is the index of the lowest set bit of `res_mask`, or the element count (16 or 8) when the mask is zero.
- R8: `flag_hit` is 1 exactly when `res_mask` is non-zero.
- R9: Outputs update on the rising edge after the inputs are applied. A synchronous active-low reset clears the mask, index and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 128 | Pattern, set or range-list operand |
| src_b | input | 128 | Operand being scanned |
| wide_sel | input | 1 | 0: byte elements, 1: word elements |
| agg_mode | input | 2 | 0 position-wise, 1 set, 2 ranges, 3 substring |
| res_mask | output | 16 | Result mask, bit k for element k of src_b |
| res_idx | output | 5 | Lowest set mask bit, or element count if none |
| flag_term | output | 1 | src_b contains a zero element |
| flag_hit | output | 1 | Mask is non-zero |

## Verification
The hardest situations to reach are where termination overrides collide with matches. Examples are a substring that begins near the top of the operand and would run past the last element, a range pair cut in half by a terminator, and a word-mode operand whose upper byte alone is zero. Uniform random data almost never produces matches or well-placed terminators. The stimulus therefore draws characters from a four-letter alphabet with a tunable share of zeros, so matches, early ends and no-end operands all occur often. Directed cases add an empty pattern, two fully occupied operands, a substring running off the top, and word elements with one zero byte.

// File: rtl/strcmp_pkg.sv
// Package: shared types for the packed string compare engine.
// Assumes element widths of 8 and 16 bits only.
package strcmp_pkg;

    localparam int CHAR_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        AGG_EACH  = 2'd0,
        AGG_ANY   = 2'd1,
        AGG_RANGE = 2'd2,
        AGG_ORDER = 2'd3
    } agg_mode_e;

endpackage

// File: rtl/str_len_scan.sv
// Module: str_len_scan
// Splits one operand into elements (zero-extended to 16 bits) and marks
// which ones lie before the first zero element. Assumes DATA_W is a
// multiple of 16. Elements beyond the word-mode count read as invalid.
module str_len_scan #(
    parameter int DATA_W = 128,
    localparam int NB = DATA_W / strcmp_pkg::CHAR_W,
    localparam int NW = DATA_W / strcmp_pkg::WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   op,
    input  logic                wide,
    output logic [NB-1:0][15:0] elems,
    output logic [NB-1:0]       valid
);

    logic [NB-1:0] is_zero;
    logic [NB-1:0] in_lane;

    // Element extraction per position, byte or word view.
    for (genvar k = 0; k < NB; k++) begin : g_elem
        logic [15:0] byte_view;
        logic [15:0] word_view;
        assign byte_view = {8'h00, op[k*8 +: 8]};
        if (k < NW) begin : g_word
            assign word_view  = op[k*16 +: 16];
            assign in_lane[k] = 1'b1;
        end else begin : g_none
            assign word_view  = 16'h0000;
            assign in_lane[k] = ~wide;
        end
        assign elems[k]   = wide ? word_view : byte_view;
        assign is_zero[k] = (elems[k] == 16'h0000);
    end

    // Prefix scan: an element is valid until the first terminator.
    always_comb begin
        valid[0] = in_lane[0] & ~is_zero[0];
        for (int k = 1; k < NB; k++) begin
            valid[k] = valid[k-1] & in_lane[k] & ~is_zero[k];
        end
    end

    // R2: valid elements always form a contiguous run from position 0.
    a_r2_valid_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid + 1'b1) & valid) == '0);

    // R1: in word mode no position above the word count is valid.
    a_r1_word_tail: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> (valid[NB-1:NW] == '0));

endmodule

// File: rtl/str_cmp_matrix.sv
// Module: str_cmp_matrix
// Builds the all-pairs grid between pattern elements (row i) and scanned
// elements (column j): equality and unsigned "scanned greater than pattern".
// Assumes elements are already zero-extended to 16 bits.
module str_cmp_matrix #(
    parameter int NB = 16
) (
    input  logic [NB-1:0][15:0]     a_el,
    input  logic [NB-1:0][15:0]     b_el,
    output logic [NB-1:0][NB-1:0]   eq_m,
    output logic [NB-1:0][NB-1:0]   gt_m
);

    // One comparator pair per grid cell.
    for (genvar i = 0; i < NB; i++) begin : g_row
        for (genvar j = 0; j < NB; j++) begin : g_col
            assign eq_m[i][j] = (b_el[j] == a_el[i]);
            assign gt_m[i][j] = (b_el[j] >  a_el[i]);
        end
    end

endmodule

// File: rtl/str_aggregate.sv
// Module: str_aggregate
// Reduces the comparison grid into a result mask under one of four modes,
// applying the invalid-element overrides. Assumes valid bits above the
// active element count are already zero; the mask is trimmed to the lanes.
module str_aggregate #(
    parameter int NB = 16,
    localparam int NW = NB / 2,
    localparam int PAIRS = NB / 2
) (
    input  logic [NB-1:0][NB-1:0] eq_m,
    input  logic [NB-1:0][NB-1:0] gt_m,
    input  logic [NB-1:0]         va,
    input  logic [NB-1:0]         vb,
    input  logic                  wide,
    input  strcmp_pkg::agg_mode_e mode,
    output logic [NB-1:0]         mask
);

    import strcmp_pkg::*;

    logic [NB-1:0]         each_r, any_r, rng_r, ord_r;
    logic [NB-1:0][NB-1:0] ord_cell;
    logic [NB-1:0]         lanes;

    // Substring cells along each diagonal, off-the-end handled structurally.
    for (genvar j = 0; j < NB; j++) begin : g_diag
        for (genvar i = 0; i < NB; i++) begin : g_cell
            if (j + i < NB) begin : g_in
                assign ord_cell[j][i] = ~va[i] | (vb[j+i] & eq_m[i][j+i]);
            end else begin : g_out
                assign ord_cell[j][i] = ~va[i];
            end
        end
        assign ord_r[j] = &ord_cell[j];
    end

    // Position-wise, set and range reductions.
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            each_r[j] = (va[j] & vb[j] & eq_m[j][j]) | (~va[j] & ~vb[j]);
            any_r[j]  = 1'b0;
            rng_r[j]  = 1'b0;
            for (int i = 0; i < NB; i++) begin
                any_r[j] = any_r[j] | (va[i] & vb[j] & eq_m[i][j]);
            end
            for (int p = 0; p < PAIRS; p++) begin
                rng_r[j] = rng_r[j] | (va[2*p] & va[2*p+1] & vb[j]
                         & (eq_m[2*p][j] | gt_m[2*p][j]) & ~gt_m[2*p+1][j]);
            end
        end
    end

    // Active lanes for the selected element size.
    always_comb begin
        lanes = '1;
        if (wide) lanes = {{(NB-NW){1'b0}}, {NW{1'b1}}};
    end

    // Mode select and lane trim.
    always_comb begin
        unique case (mode)
            AGG_EACH:  mask = each_r & lanes;
            AGG_ANY:   mask = any_r  & lanes;
            AGG_RANGE: mask = rng_r  & lanes;
            default:   mask = ord_r  & lanes;
        endcase
    end

endmodule

// File: rtl/str_lsb_index.sv
// Module: str_lsb_index
// Finds the lowest set bit of the mask; returns the element count if none.
// Assumes mask bits above the active element count are zero.
module str_lsb_index #(
    parameter int NB = 16,
    localparam int IDX_W = $clog2(NB + 1)
) (
    input  logic [NB-1:0]    mask,
    input  logic             wide,
    output logic [IDX_W-1:0] idx
);

    // Downward scan so the lowest set bit wins.
    always_comb begin
        idx = wide ? IDX_W'(NB / 2) : IDX_W'(NB);
        for (int k = NB - 1; k >= 0; k--) begin
            if (mask[k]) idx = IDX_W'(k);
        end
    end

endmodule

// File: rtl/str_match_engine.sv
// Module: str_match_engine (top)
// Packed string compare: splits both operands, builds the comparison grid,
// reduces it by mode, and registers mask, index and flags. One cycle latency.
// Assumes DATA_W = 128 for the port widths below.
module str_match_engine #(
    parameter int DATA_W = 128,
    localparam int NB = DATA_W / strcmp_pkg::CHAR_W,
    localparam int NW = DATA_W / strcmp_pkg::WORD_W,
    localparam int IDX_W = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              wide_sel,
    input  logic [1:0]        agg_mode,
    output logic [NB-1:0]     res_mask,
    output logic [IDX_W-1:0]  res_idx,
    output logic              flag_term,
    output logic              flag_hit
);

    import strcmp_pkg::*;

    logic [NB-1:0][15:0]   a_el, b_el;
    logic [NB-1:0]         va, vb;
    logic [NB-1:0][NB-1:0] eq_m, gt_m;
    logic [NB-1:0]         mask_c;
    logic [IDX_W-1:0]      idx_c;
    logic                  term_c;
    agg_mode_e             mode_c;
    logic                  chk_live_q;

    assign mode_c = agg_mode_e'(agg_mode);

    str_len_scan #(.DATA_W(DATA_W)) u_scan_a (
        .clk(clk), .rst_n(rst_n), .op(src_a), .wide(wide_sel),
        .elems(a_el), .valid(va)
    );

    str_len_scan #(.DATA_W(DATA_W)) u_scan_b (
        .clk(clk), .rst_n(rst_n), .op(src_b), .wide(wide_sel),
        .elems(b_el), .valid(vb)
    );

    str_cmp_matrix #(.NB(NB)) u_matrix (
        .a_el(a_el), .b_el(b_el), .eq_m(eq_m), .gt_m(gt_m)
    );

    str_aggregate #(.NB(NB)) u_agg (
        .eq_m(eq_m), .gt_m(gt_m), .va(va), .vb(vb),
        .wide(wide_sel), .mode(mode_c), .mask(mask_c)
    );

    str_lsb_index #(.NB(NB)) u_index (
        .mask(mask_c), .wide(wide_sel), .idx(idx_c)
    );

    // Terminator present in the scanned operand: last active lane invalid.
    assign term_c = wide_sel ? ~vb[NW-1] : ~vb[NB-1];

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_mask  <= '0;
            res_idx   <= '0;
            flag_term <= 1'b0;
            flag_hit  <= 1'b0;
        end else begin
            res_mask  <= mask_c;
            res_idx   <= idx_c;
            flag_term <= term_c;
            flag_hit  <= |mask_c;
        end
    end

    // Marks cycles whose previous edge was out of reset, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live_q <= 1'b0;
        else        chk_live_q <= 1'b1;
    end

    // R7: no mask bit is set below the reported index.
    a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (res_mask & ((NB'(1) << res_idx) - NB'(1))) == '0);

    // R8: a raised hit flag points at a set mask bit.
    a_r8_hit_bit: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hit |-> ((res_mask >> res_idx) & NB'(1)) == NB'(1));

    // R1: word-mode results leave the upper mask half clear.
    a_r1_word_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live_q && $past(wide_sel)) |-> (res_mask[NB-1:NW] == '0));

endmodule

// File: tb/tb_str_match_engine.sv
module tb_str_match_engine;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_a = '0, src_b = '0;
    logic         wide_sel = 1'b0;
    logic [1:0]   agg_mode = 2'd0;
    logic [15:0]  res_mask;
    logic [4:0]   res_idx;
    logic         flag_term, flag_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    str_match_engine dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .wide_sel(wide_sel), .agg_mode(agg_mode), .res_mask(res_mask),
        .res_idx(res_idx), .flag_term(flag_term), .flag_hit(flag_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] el(logic [127:0] op, int k, bit w);
        return w ? op[k*16 +: 16] : {8'h00, op[k*8 +: 8]};
    endfunction

    // Reference model written from the requirements R1..R8.
    task automatic ref_calc(input logic [127:0] a, input logic [127:0] b,
                            input bit w, input logic [1:0] m,
                            output logic [15:0] mask, output logic [4:0] idx,
                            output bit term, output bit hit);
        int n, la, lb;
        bit fa, fb, r, va, vb;
        n = w ? 8 : 16;
        la = n; lb = n; fa = 0; fb = 0;
        for (int k = 0; k < n; k++) begin
            if (!fa && el(a, k, w) == 0) begin la = k; fa = 1; end
            if (!fb && el(b, k, w) == 0) begin lb = k; fb = 1; end
        end
        mask = '0;
        for (int j = 0; j < n; j++) begin
            vb = (j < lb);
            r = 0;
            case (m)
                2'd0: begin
                    va = (j < la);
                    if (va && vb) r = (el(a, j, w) == el(b, j, w));
                    else          r = (!va && !vb);
                end
                2'd1: for (int i = 0; i < la; i++)
                          if (vb && el(a, i, w) == el(b, j, w)) r = 1;
                2'd2: for (int p = 0; 2*p + 1 < la; p++)
                          if (vb && el(b, j, w) >= el(a, 2*p, w) &&
                              el(b, j, w) <= el(a, 2*p+1, w)) r = 1;
                default: begin
                    r = 1;
                    for (int i = 0; i < la; i++)
                        if (j + i >= n || j + i >= lb ||
                            el(a, i, w) != el(b, j + i, w)) r = 0;
                end
            endcase
            mask[j] = r;
        end
        idx = 5'(n);
        for (int k = n - 1; k >= 0; k--) if (mask[k]) idx = 5'(k);
        term = (lb < n);
        hit = (mask != 0);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] str16(string s);
        logic [127:0] v = '0;
        for (int k = 0; k < s.len() && k < 16; k++) v[k*8 +: 8] = s[k];
        return v;
    endfunction

    // Random operand from a small alphabet; zero_pct sets terminator odds.
    function automatic logic [127:0] rand_op(bit w, int zero_pct);
        logic [127:0] v = '0;
        int n = w ? 8 : 16;
        for (int k = 0; k < n; k++) begin
            logic [15:0] c;
            if (($urandom % 100) < zero_pct) c = 16'h0000;
            else if (w && ($urandom % 4) == 0) c = 16'h6100 + 16'($urandom % 4);
            else c = 16'h0061 + 16'($urandom % 4);
            if (w) v[k*16 +: 16] = c; else v[k*8 +: 8] = c[7:0];
        end
        return v;
    endfunction

    task automatic apply(logic [127:0] a, logic [127:0] b, bit w, logic [1:0] m);
        logic [15:0] e_mask;
        logic [4:0]  e_idx;
        bit e_term, e_hit;
        string mtag [4] = '{"R3", "R4", "R5", "R6"};
        @(negedge clk);
        src_a = a; src_b = b; wide_sel = w; agg_mode = m;
        ref_calc(a, b, w, m, e_mask, e_idx, e_term, e_hit);
        @(negedge clk);  // R9: result registered at the edge in between
        chk(res_mask == e_mask, mtag[m], "mask", res_mask, e_mask);
        chk(res_idx == e_idx, "R7", "index", res_idx, e_idx);
        chk(flag_term == e_term, "R2", "term flag", flag_term, e_term);
        chk(flag_hit == e_hit, "R8", "hit flag", flag_hit, e_hit);
        if (w) chk(res_mask[15:8] == 8'h00, "R1", "word upper mask", res_mask[15:8], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        src_a = str16("abcd"); src_b = str16("abcd"); agg_mode = 2'd1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(res_mask == 16'h0, "R9", "reset mask", res_mask, 0);
        chk(res_idx == 5'h0, "R9", "reset index", res_idx, 0);
        chk(flag_term == 1'b0 && flag_hit == 1'b0, "R9", "reset flags",
            {flag_term, flag_hit}, 0);
        rst_n = 1'b1;

        // Directed corner cases
        apply(str16("abcd"), str16("xxabcdab"), 0, 2'd3);      // R6 substring
        apply(str16(""), str16("ab"), 0, 2'd3);                // R6 empty pattern
        apply(str16("abc"), str16("xxxxxxxxxxxxxxab"), 0, 2'd3); // R6 runs off top
        apply({16{8'h61}}, {16{8'h61}}, 0, 2'd0);              // R2 no terminator
        apply(str16("ab"), str16("ab"), 0, 2'd0);              // R3 both invalid tail
        apply(str16("az09z"), str16("qM5z0"), 0, 2'd2);        // R5 half pair
        apply(str16("aeiou"), str16("house"), 0, 2'd1);        // R4
        apply(str16("zz"), str16("abc"), 0, 2'd1);             // R7 empty mask
        // R1 word mode with zero low byte only, and a zero word
        apply({112'h0, 16'h6100}, {96'h0, 16'h0061, 16'h6100}, 1, 2'd1);
        apply({8{16'h0061}}, {8{16'h0061}}, 1, 2'd0);

        // Constrained random
        for (int t = 0; t < 600; t++) begin
            bit w = 1'($urandom % 2);
            int zp = (t % 3 == 0) ? 0 : 10;
            apply(rand_op(w, zp), rand_op(w, zp), w, 2'($urandom % 4));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule